// File: doc/BRIEF.md
# Four-Channel Triggered Pulse Delay Generator

This block turns one external trigger event into four timed output pulses. A gate input qualifies each trigger. An optional countdown stage passes only every Nth qualified trigger. Once a trigger is accepted, a tick counter runs from zero. Each channel compares that count against its own rise and fall counts. The channel output is high from its rise tick until its fall tick. Burst mode replays the whole four-channel pattern a programmed number of times, with an idle gap between passes.

Each of the eight coarse edges carries a 7-bit fine-delay code for external trim logic. The code is latched onto a per-edge output lane, and a one-cycle strobe marks the cycle in which the coarse edge takes effect. One clock cycle of the block is one coarse tick. All settings are written through a small synchronous write port. While a sequence is in flight, the write port is locked.

Top module: `pdg_top`

## Requirements
- R1: After reset, `ch_out`, `fine_stb` and `busy` are all zero. All counts, codes and mode settings are zero, which means one pass, N = 1 and a zero gap.
- R2: A trigger starts a sequence only if `gate_in` is high in the same cycle as `trig_in`. With `gate_in` low, no sequence starts.
- R3: If a trigger is accepted at clock edge E, channel k goes high at edge E+1+rise_k and low at edge E+1+fall_k.
- R4: A channel whose fall count is not greater than its rise count stays low for the whole sequence. It issues no strobes, and its fine-code lanes keep their old values.
- R5: `busy` goes high at the edge after acceptance. It stays high until the edge at which the tick count reaches the largest fall count of the final pass. Triggers that arrive while `busy` is high are dropped and do not advance the countdown.
- R6: The countdown register at address 16 holds N-1 in bits [7:0]. Only the Nth qualified idle trigger starts a sequence. Writing this register restarts the count.
- R7: Address 17 holds M-1 in bits [7:0], and address 18 holds the gap G. The pattern runs M times. Each new pass restarts its tick count G+1 edges after the previous pass reaches its largest fall count.
- R8: Strobe `fine_stb[2k]` pulses for one cycle together with the rising edge of channel k, and `fine_stb[2k+1]` together with its falling edge. Lane e of `fine_code` (bits e*7+6 down to e*7) then holds the code written at address 8+e.
- R9: Configuration writes made while `busy` is high have no effect.
- R10: Rise count k is written at address k and fall count k at address 4+k, using data bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_in | input | 1 | Trigger event, one cycle per event |
| gate_in | input | 1 | Trigger qualifier |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| ch_out | output | 4 | Channel pulse outputs |
| fine_stb | output | 8 | Per-edge strobe, even = rise, odd = fall |
| fine_code | output | 56 | Per-edge fine-delay code lanes, 7 bits each |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions assume that `cfg_we` is never raised in the same cycle as an accepted trigger. They also assume that triggers are synchronous, single-cycle events. The stimulus satisfies both: writes are made only while the block is idle (apart from deliberate writes during `busy`), and each trigger is driven high for exactly one cycle between falling edges. Given that write discipline, the channel-level checks rely on configuration being frozen while any output is high. The scoreboard predicts every cycle of each sequence from the programmed counts. It thereby shows that triggers and writes injected mid-sequence leave the waveform unchanged.

// File: rtl/pdg_pkg.sv
// Shared constants and types for the pulse delay generator.
package pdg_pkg;
    localparam int NCH_D = 4;   // output channels
    localparam int CW_D  = 16;  // tick count width
    localparam int FW_D  = 7;   // fine code width
    localparam int PW_D  = 8;   // countdown / burst field width

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_GAP  = 2'd2
    } seq_st_t;
endpackage

// File: rtl/pdg_cfg.sv
// Configuration register file.
// Holds per-channel rise/fall counts, per-edge fine codes and the
// countdown, burst and gap settings. Writes are dropped while lock is high.
// Assumes single-cycle write strobes on the block clock.
module pdg_cfg #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int FW  = 7,
    parameter int PW  = 8,
    parameter int AW  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             addr,
    input  logic [CW-1:0]             wdata,
    input  logic                      lock,
    output logic [NCH-1:0][CW-1:0]    rise_q,
    output logic [NCH-1:0][CW-1:0]    fall_q,
    output logic [2*NCH-1:0][FW-1:0]  fine_q,
    output logic [PW-1:0]             cd_n,
    output logic [PW-1:0]             burst_m,
    output logic [CW-1:0]             gap_q,
    output logic                      cd_clr
);
    localparam int A_FALL0 = NCH;
    localparam int A_FINE0 = 2*NCH;
    localparam int A_CDN   = 4*NCH;
    localparam int A_BURST = 4*NCH + 1;
    localparam int A_GAP   = 4*NCH + 2;

    logic wr_ok;
    assign wr_ok  = we && !lock;
    assign cd_clr = wr_ok && (addr == AW'(A_CDN));

    // Register update: decode the address and load the selected field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q  <= '0;
            fall_q  <= '0;
            fine_q  <= '0;
            cd_n    <= '0;
            burst_m <= '0;
            gap_q   <= '0;
        end else if (wr_ok) begin
            for (int k = 0; k < NCH; k++) begin
                if (addr == AW'(k))           rise_q[k] <= wdata;
                if (addr == AW'(A_FALL0 + k)) fall_q[k] <= wdata;
            end
            for (int e = 0; e < 2*NCH; e++) begin
                if (addr == AW'(A_FINE0 + e)) fine_q[e] <= wdata[FW-1:0];
            end
            if (addr == AW'(A_CDN))   cd_n    <= wdata[PW-1:0];
            if (addr == AW'(A_BURST)) burst_m <= wdata[PW-1:0];
            if (addr == AW'(A_GAP))   gap_q   <= wdata;
        end
    end

    // R9: a locked write leaves the timing registers untouched
    p_locked_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && lock) |=> ($stable(rise_q) && $stable(fall_q) && $stable(gap_q)));
endmodule

// File: rtl/pdg_trig.sv
// Trigger qualifier and countdown prescaler.
// A trigger counts only when gated and the sequencer is idle; the Nth
// such trigger (N = cd_n + 1) raises start. Assumes trig is one cycle wide.
module pdg_trig #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          gate,
    input  logic          busy,
    input  logic [PW-1:0] cd_n,
    input  logic          cd_clr,
    output logic          start
);
    logic [PW-1:0] cnt;
    logic          qual;

    assign qual  = trig && gate && !busy;
    assign start = qual && (cnt == cd_n);

    // Countdown: advance on each qualified trigger, wrap when one starts.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (cd_clr) cnt <= '0;
        else if (qual)   cnt <= start ? '0 : cnt + 1'b1;
    end

    // R6: the count never passes the programmed limit
    p_cd_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= cd_n);
endmodule

// File: rtl/pdg_seq.sv
// Sequence controller: runs the shared tick count for M passes with a gap.
// A pass ends when the tick count equals 'last' (the largest fall count).
// Assumes configuration is stable while busy.
module pdg_seq #(
    parameter int CW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] last,
    input  logic [PW-1:0] burst_m,
    input  logic [CW-1:0] gap,
    output logic          run,
    output logic [CW-1:0] tick,
    output logic          busy
);
    import pdg_pkg::*;

    seq_st_t       st;
    logic [CW-1:0] t;
    logic [CW-1:0] g;
    logic [PW-1:0] reps;

    assign run  = (st == S_RUN);
    assign busy = (st != S_IDLE);
    assign tick = t;

    // State machine: idle -> run -> (gap -> run)* -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            t    <= '0;
            g    <= '0;
            reps <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    st   <= S_RUN;
                    t    <= '0;
                    reps <= burst_m;
                end
                S_RUN: if (t == last) begin
                    if (reps != '0) begin
                        st   <= S_GAP;
                        g    <= '0;
                        reps <= reps - 1'b1;
                    end else begin
                        st <= S_IDLE;
                    end
                end else begin
                    t <= t + 1'b1;
                end
                S_GAP: if (g == gap) begin
                    st <= S_RUN;
                    t  <= '0;
                end else begin
                    g <= g + 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R5: an accepted trigger makes the block busy on the next edge
    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R7: a gap can only end in a fresh pass that begins at tick zero
    p_gap_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_GAP) |=> ((st == S_GAP) || (st == S_RUN && t == '0)));
endmodule

// File: rtl/pdg_edge.sv
// One channel's edge unit: compares the shared tick with its rise and
// fall counts, drives the pulse level, and latches fine codes with strobes.
// Assumes rise/fall are stable while run is high.
module pdg_edge #(
    parameter int CW = 16,
    parameter int FW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] tick,
    input  logic [CW-1:0] rise,
    input  logic [CW-1:0] fall,
    input  logic [FW-1:0] code_r,
    input  logic [FW-1:0] code_f,
    output logic          lvl,
    output logic          stb_r,
    output logic          stb_f,
    output logic [FW-1:0] cq_r,
    output logic [FW-1:0] cq_f
);
    logic active, hit_r, hit_f;

    assign active = rise < fall;
    assign hit_r  = run && active && (tick == rise);
    assign hit_f  = run && active && (tick == fall);

    // Edge action: set/clear the level, pulse strobes, capture codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl   <= 1'b0;
            stb_r <= 1'b0;
            stb_f <= 1'b0;
            cq_r  <= '0;
            cq_f  <= '0;
        end else begin
            stb_r <= hit_r;
            stb_f <= hit_f;
            if (hit_f)      lvl <= 1'b0;
            else if (hit_r) lvl <= 1'b1;
            if (hit_r) cq_r <= code_r;
            if (hit_f) cq_f <= code_f;
        end
    end

    // R4: a high level implies a channel with fall above rise
    p_level_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl |-> (rise < fall));
    // R8: the rise strobe accompanies the rising level
    p_rise_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl) |-> stb_r);
    // R8: the fall strobe accompanies the falling level
    p_fall_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lvl) |-> stb_f);
    // R8: the two strobes of one channel never coincide
    p_stb_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb_r && stb_f));
endmodule

// File: rtl/pdg_top.sv
// Four-channel triggered pulse delay generator, top level.
// Wires the config file, trigger qualifier, sequencer and one edge unit
// per channel. One clock cycle is one coarse tick.
module pdg_top #(
    parameter int NCH = pdg_pkg::NCH_D,
    parameter int CW  = pdg_pkg::CW_D,
    parameter int FW  = pdg_pkg::FW_D,
    parameter int PW  = pdg_pkg::PW_D,
    localparam int AW = $clog2(4*NCH + 3),
    localparam int NE = 2*NCH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             gate_in,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CW-1:0]    cfg_wdata,
    output logic [NCH-1:0]   ch_out,
    output logic [NE-1:0]    fine_stb,
    output logic [NE*FW-1:0] fine_code,
    output logic             busy
);
    logic [NCH-1:0][CW-1:0] rise_q, fall_q;
    logic [NE-1:0][FW-1:0]  fine_q;
    logic [PW-1:0]          cd_n, burst_m;
    logic [CW-1:0]          gap_q, last, tick;
    logic                   cd_clr, start, run;

    pdg_cfg #(.NCH(NCH), .CW(CW), .FW(FW), .PW(PW), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .lock(busy), .rise_q(rise_q), .fall_q(fall_q),
        .fine_q(fine_q), .cd_n(cd_n), .burst_m(burst_m), .gap_q(gap_q),
        .cd_clr(cd_clr)
    );

    pdg_trig #(.PW(PW)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig(trig_in), .gate(gate_in),
        .busy(busy), .cd_n(cd_n), .cd_clr(cd_clr), .start(start)
    );

    // Pass length: the largest fall count over all channels.
    always_comb begin
        last = '0;
        for (int k = 0; k < NCH; k++)
            if (fall_q[k] > last) last = fall_q[k];
    end

    pdg_seq #(.CW(CW), .PW(PW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .last(last),
        .burst_m(burst_m), .gap(gap_q), .run(run), .tick(tick), .busy(busy)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        pdg_edge #(.CW(CW), .FW(FW)) u_edge (
            .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
            .rise(rise_q[k]), .fall(fall_q[k]),
            .code_r(fine_q[2*k]), .code_f(fine_q[2*k+1]),
            .lvl(ch_out[k]), .stb_r(fine_stb[2*k]), .stb_f(fine_stb[2*k+1]),
            .cq_r(fine_code[(2*k)*FW +: FW]),
            .cq_f(fine_code[(2*k+1)*FW +: FW])
        );
    end

    // R5: no channel is high outside a running sequence
    p_out_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_out) |-> busy);
endmodule

// File: tb/sim_pdg_top.sv
// Scoreboard bench: the driver predicts each sequence cycle by cycle,
// the monitor compares outputs at every falling edge.
module sim_pdg_top;
    logic        clk = 1'b0;
    logic        rst_n, trig_in, gate_in, cfg_we;
    logic [4:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic [3:0]  ch_out;
    logic [7:0]  fine_stb;
    logic [55:0] fine_code;
    logic        busy;

    always #4 clk = ~clk;

    pdg_top u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .gate_in(gate_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ch_out(ch_out), .fine_stb(fine_stb), .fine_code(fine_code),
        .busy(busy)
    );

    typedef struct {
        logic [3:0] out;
        logic       bsy;
        logic [7:0] stb;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int   total = 0;
    int   bad   = 0;
    int   m_rise[4], m_fall[4], m_fine[8];
    int   m_reps = 1, m_gap = 0;

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
        end
    endtask

    // Monitor: pop one predicted cycle per falling edge and compare.
    always @(negedge clk) begin
        exp_t e;
        if (sbq.size() != 0) begin
            e = sbq.pop_front();
            chk(ch_out === e.out, e.tag, "ch_out", int'(ch_out), int'(e.out));
            chk(busy === e.bsy, e.tag, "busy", int'(busy), int'(e.bsy));
            chk(fine_stb === e.stb, e.tag, "fine_stb", int'(fine_stb), int'(e.stb));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_ch(int k, int r, int f);
        wr(k, r); wr(4 + k, f);
        m_rise[k] = r; m_fall[k] = f;
    endtask

    // Predict every cycle from the acceptance edge to the return to idle.
    task automatic push_seq(string tag);
        int last = 0, xend, st = 0;
        int starts[8];
        exp_t e;
        for (int k = 0; k < 4; k++) if (m_fall[k] > last) last = m_fall[k];
        for (int r = 0; r < m_reps; r++) begin
            starts[r] = st;
            st = st + 1 + last + 1 + m_gap;
        end
        xend = starts[m_reps-1] + 1 + last;
        for (int j = 0; j <= xend; j++) begin
            e.out = '0; e.stb = '0; e.tag = tag;
            e.bsy = (j < xend);
            for (int r = 0; r < m_reps; r++)
                for (int k = 0; k < 4; k++)
                    if (m_rise[k] < m_fall[k]) begin
                        if (j >= starts[r]+1+m_rise[k] && j < starts[r]+1+m_fall[k]) e.out[k] = 1'b1;
                        if (j == starts[r]+1+m_rise[k]) e.stb[2*k] = 1'b1;
                        if (j == starts[r]+1+m_fall[k]) e.stb[2*k+1] = 1'b1;
                    end
            sbq.push_back(e);
        end
    endtask

    // Driver: accepted trigger; optional triggers and a write while busy.
    task automatic run(string tag, bit poke);
        int i = 0;
        @(negedge clk);
        trig_in = 1'b1; gate_in = 1'b1;
        @(posedge clk);
        push_seq(tag);
        @(negedge clk);
        trig_in = 1'b0; gate_in = 1'b0;
        while (sbq.size() != 0) begin
            i++;
            if (poke) begin
                trig_in = (i == 2 || i == 4);
                gate_in = trig_in;
                cfg_we = (i == 6); cfg_addr = 5'd0; cfg_wdata = 16'd7;
            end
            @(negedge clk);
        end
        trig_in = 1'b0; gate_in = 1'b0; cfg_we = 1'b0;
    endtask

    // A trigger that must not start a sequence.
    task automatic pulse(bit g, string tag);
        @(negedge clk);
        trig_in = 1'b1; gate_in = g;
        @(negedge clk);
        trig_in = 1'b0; gate_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, tag, "busy", int'(busy), 0);
        chk(ch_out === 4'h0, tag, "ch_out", int'(ch_out), 0);
    endtask

    task automatic chk_fine(string tag);
        for (int e = 0; e < 8; e++)
            chk(int'(fine_code[e*7 +: 7]) == m_fine[e], tag, "fine_code",
                int'(fine_code[e*7 +: 7]), m_fine[e]);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; trig_in = 1'b0; gate_in = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        for (int e = 0; e < 8; e++) m_fine[e] = 0;
        for (int k = 0; k < 4; k++) begin m_rise[k] = 0; m_fall[k] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ch_out === 4'h0, "R1", "ch_out", int'(ch_out), 0);
        chk(busy === 1'b0, "R1", "busy", int'(busy), 0);
        chk(fine_stb === 8'h0, "R1", "fine_stb", int'(fine_stb), 0);
        chk(fine_code === '0, "R1", "fine_code", int'(fine_code[31:0]), 0);

        // R10 map; R4: channel 2 has fall == rise and stays low
        set_ch(0, 2, 5); set_ch(1, 0, 1); set_ch(2, 4, 4); set_ch(3, 1, 9);
        for (int e = 0; e < 8; e++) wr(8 + e, e*9 + 3);
        run("R3 R4 R8", 1'b0);
        // R8 codes latched on active edges; R4 inactive lanes untouched
        for (int e = 0; e < 8; e++) m_fine[e] = (e/2 == 2) ? 0 : e*9 + 3;
        chk_fine("R8 R4");

        // R2: gate low blocks a trigger
        pulse(1'b0, "R2");

        // R7: three passes with a gap of 3
        wr(17, 2); wr(18, 3); m_reps = 3; m_gap = 3;
        run("R7", 1'b0);
        wr(18, 0); m_gap = 0;
        run("R7 gap0", 1'b0);
        wr(17, 0); m_reps = 1;

        // R6 countdown N=2; R5 busy triggers dropped; R9 busy write dropped
        wr(16, 1);
        pulse(1'b1, "R6");
        run("R6 R5 R9", 1'b1);
        pulse(1'b1, "R5");
        run("R9 R6", 1'b0);
        wr(16, 0);

        // R3 second pattern, all channels active
        set_ch(1, 10, 12); set_ch(2, 3, 7);
        run("R3", 1'b0);
        for (int e = 0; e < 8; e++) m_fine[e] = e*9 + 3;
        chk_fine("R8");

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule